// File: doc/BRIEF.md
# Landing-Pad Target Checker

This block guards indirect control transfers into a code region. It keeps one bit for each halfword of the region, marking the offsets at which a basic block may legally begin. Blocks are never tagged in the code itself. The set is built from the shape of the instruction stream: offset zero always counts, any instruction that follows a block-ending instruction counts, and a host or management call counts at its own address and at the address after it. Such a call is therefore a block of its own.

After a `clear`, a decoder feeds one record per instruction: its halfword offset, whether it is 2 or 4 bytes long, whether it ends a block, and whether it is a host call. It then raises `seal`. After that, any indirect-jump target or entry address for a fresh invocation can be presented as a 64-bit value. Only the low 32 bits take part. The code base is subtracted from them and the result is looked up in the bitmap. One cycle later the block reports either pass or a fatal trap. A trap also sets a sticky fatal flag, which stays set until the next `clear`. No class of jump is exempt, and returns go through the same check.

Top module: `cfi_landing_checker`

## Requirements
- R1: After reset, and after a `clear`, the only valid start is relative offset 0. A target equal to `CODE_BASE` passes and `CODE_BASE+2` traps.
- R2: A record with `rec_term` set marks the halfword right after the instruction as a start. That is `rec_hw+1` when `rec_len4`=0 (2 bytes) and `rec_hw+2` when `rec_len4`=1 (4 bytes). A record with neither `rec_term` nor `rec_host` set adds no start.
- R3: A record with `rec_host` set marks both its own halfword `rec_hw` and the halfword after the instruction as starts.
- R4: Bits 63:32 of `chk_target` have no effect. The relative offset is `chk_target[31:0] - CODE_BASE`, and halfword index = relative offset / 2.
- R5: A target traps when any of the following holds: its low 32 bits are below `CODE_BASE`; its relative offset is `CODE_BYTES` or more; its relative offset is odd; or the halfword it names is not a start.
- R6: A check accepted at edge k drives `res_valid`=1 after edge k+1. In that same cycle exactly one of `res_pass` or `res_trap` is 1. With no accepted check, all three are 0.
- R7: `busy` is 1 from the edge after `clear` until the edge after `seal`. A check is accepted only when `busy`=0 and `clear`=0. A check presented while busy produces no result. Records presented while not busy leave the start set unchanged.
- R8: `fatal` becomes 1 together with any trap result and stays 1 until `clear` or reset. Later passing checks do not lower it.
- R9: A start whose index would fall at or beyond the end of the region is dropped, and halfword 0 is not set by wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty the start set (keeping offset 0) and enter build mode |
| seal | input | 1 | Leave build mode |
| rec_valid | input | 1 | Instruction record present |
| rec_hw | input | HW_W | Halfword offset of the instruction |
| rec_len4 | input | 1 | 1 = 4-byte instruction, 0 = 2-byte |
| rec_term | input | 1 | Instruction ends a basic block |
| rec_host | input | 1 | Instruction is a host or management call |
| chk_valid | input | 1 | Check request present |
| chk_target | input | 64 | Jump target or entry address |
| busy | output | 1 | Build in progress; checks are refused |
| res_valid | output | 1 | Result present |
| res_pass | output | 1 | Target is a valid start |
| res_trap | output | 1 | Fatal trap on the target |
| fatal | output | 1 | Sticky trap flag |

## Verification
The bench goes after the edges of the region, at `CODE_BASE-2`, at the last halfword, and at `CODE_BASE+CODE_BYTES`. A wrong range compare would let the first or last of these through, or turn the last halfword into a trap. It also sends targets whose upper 32 bits are random, and targets at odd byte offsets. A design that compares all 64 bits would trap on the first kind, and a design that drops the low bit before the lookup would pass the second. It places a block-ending instruction at the very end of the region to catch an index that wraps onto halfword 0. Finally, it issues checks while a build is running and records after sealing. A design with a missing mode gate would return stale results or would mark starts without a build.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

   // Build/check mode of the start-set store
   typedef enum logic {
      MODE_CHECK = 1'b0,
      MODE_BUILD = 1'b1
   } cfi_mode_e;

   // Halfwords spanned by one instruction
   function automatic logic [1:0] span_hw(input logic len4);
      return len4 ? 2'd2 : 2'd1;
   endfunction

endpackage

// File: rtl/cfi_target_xlate.sv
module cfi_target_xlate #(
   parameter logic [31:0] CODE_BASE  = 32'h0040_0000,
   parameter int unsigned CODE_BYTES = 512,
   localparam int unsigned HW_CNT    = CODE_BYTES / 2,
   localparam int unsigned HW_W      = $clog2(HW_CNT)
) (
   input  logic [31:0]     addr_lo,
   output logic            in_region,
   output logic [HW_W-1:0] hw_idx
);

   logic [31:0] rel;

   always_comb begin
      rel       = addr_lo - CODE_BASE;
      in_region = (addr_lo >= CODE_BASE) && (rel < 32'(CODE_BYTES)) && !rel[0];
      hw_idx    = rel[HW_W:1];
   end

endmodule

// File: rtl/cfi_padmap.sv
module cfi_padmap #(
   parameter int unsigned HW_CNT = 256,
   localparam int unsigned HW_W  = $clog2(HW_CNT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            wr_en,
   input  logic [HW_W-1:0] rec_hw,
   input  logic            rec_len4,
   input  logic            rec_term,
   input  logic            rec_host,
   input  logic [HW_W-1:0] rd_idx,
   output logic            rd_bit
);
   import cfi_pkg::*;

   logic [HW_CNT-1:0] map_q;
   logic [HW_W:0]     succ_hw;
   logic              mark_succ;
   logic              mark_self;

   // Successor index is one bit wider so that the end of region never aliases
   always_comb begin
      succ_hw   = {1'b0, rec_hw} + (HW_W+1)'(span_hw(rec_len4));
      mark_succ = wr_en && (rec_term || rec_host);
      mark_self = wr_en && rec_host;
   end

   for (genvar i = 0; i < HW_CNT; i++) begin : g_bit
      localparam logic INIT = (i == 0);
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            map_q[i] <= INIT;
         end else if ((mark_succ && succ_hw == (HW_W+1)'(i)) ||
                      (mark_self && rec_hw == HW_W'(i))) begin
            map_q[i] <= 1'b1;
         end
      end
   end

   assign rd_bit = map_q[rd_idx];

endmodule

// File: rtl/cfi_landing_checker.sv
module cfi_landing_checker #(
   parameter logic [31:0] CODE_BASE  = 32'h0040_0000,
   parameter int unsigned CODE_BYTES = 512,
   localparam int unsigned HW_CNT    = CODE_BYTES / 2,
   localparam int unsigned HW_W      = $clog2(HW_CNT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            seal,
   input  logic            rec_valid,
   input  logic [HW_W-1:0] rec_hw,
   input  logic            rec_len4,
   input  logic            rec_term,
   input  logic            rec_host,
   input  logic            chk_valid,
   input  logic [63:0]     chk_target,
   output logic            busy,
   output logic            res_valid,
   output logic            res_pass,
   output logic            res_trap,
   output logic            fatal
);
   import cfi_pkg::*;

   // Elaboration-time parameter checks
   if (CODE_BYTES < 4 || (CODE_BYTES & (CODE_BYTES - 1)) != 0) begin : g_bad_size
      $error("CODE_BYTES must be a power of two and at least 4");
   end
   if (CODE_BASE[0] != 1'b0) begin : g_bad_base
      $error("CODE_BASE must be halfword aligned");
   end
   if (64'(CODE_BASE) + 64'(CODE_BYTES) > 64'h1_0000_0000) begin : g_bad_span
      $error("code region must fit below 4 GiB");
   end

   cfi_mode_e   mode_q;
   logic        wr_en;
   logic        chk_fire;
   logic        in_region;
   logic [HW_W-1:0] hw_idx;
   logic        start_bit;
   logic        ok;
   logic        unused_upper;

   assign unused_upper = ^chk_target[63:32];
   assign busy     = (mode_q == MODE_BUILD);
   assign wr_en    = rec_valid && busy && !clear;
   assign chk_fire = chk_valid && !busy && !clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_CHECK;
      end else if (clear) begin
         mode_q <= MODE_BUILD;
      end else if (seal) begin
         mode_q <= MODE_CHECK;
      end
   end

   cfi_target_xlate #(
      .CODE_BASE (CODE_BASE),
      .CODE_BYTES(CODE_BYTES)
   ) u_xlate (
      .addr_lo  (chk_target[31:0]),
      .in_region(in_region),
      .hw_idx   (hw_idx)
   );

   cfi_padmap #(
      .HW_CNT(HW_CNT)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .wr_en   (wr_en),
      .rec_hw  (rec_hw),
      .rec_len4(rec_len4),
      .rec_term(rec_term),
      .rec_host(rec_host),
      .rd_idx  (hw_idx),
      .rd_bit  (start_bit)
   );

   assign ok = in_region && start_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
         res_trap  <= 1'b0;
         fatal     <= 1'b0;
      end else begin
         res_valid <= chk_fire;
         res_pass  <= chk_fire && ok;
         res_trap  <= chk_fire && !ok;
         if (clear) begin
            fatal <= 1'b0;
         end else if (chk_fire && !ok) begin
            fatal <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfi_landing_checker_sva.sv
module cfi_landing_checker_sva #(
   parameter logic [31:0] CODE_BASE  = 32'h0040_0000,
   parameter int unsigned CODE_BYTES = 512
) (
   input logic        clk,
   input logic        rst_n,
   input logic        clear,
   input logic        seal,
   input logic        chk_valid,
   input logic [63:0] chk_target,
   input logic        busy,
   input logic        res_valid,
   input logic        res_pass,
   input logic        res_trap,
   input logic        fatal
);

   p_result_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !busy && !clear) |=> res_valid);

   p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_pass ^ res_trap));

   p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_pass && !res_trap));

   p_refuse_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && busy) |=> !res_valid);

   p_busy_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> busy);

   p_idle_after_seal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seal && !clear) |=> !busy);

   p_below_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !busy && !clear && chk_target[31:0] < CODE_BASE) |=> res_trap);

   p_past_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !busy && !clear && chk_target[31:0] >= CODE_BASE &&
       (chk_target[31:0] - CODE_BASE) >= 32'(CODE_BYTES)) |=> res_trap);

   p_trap_raises_fatal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_trap |-> fatal);

   p_fatal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal && !clear) |=> fatal);

   p_fatal_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !fatal);

endmodule

bind cfi_landing_checker cfi_landing_checker_sva #(
   .CODE_BASE (CODE_BASE),
   .CODE_BYTES(CODE_BYTES)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .clear     (clear),
   .seal      (seal),
   .chk_valid (chk_valid),
   .chk_target(chk_target),
   .busy      (busy),
   .res_valid (res_valid),
   .res_pass  (res_pass),
   .res_trap  (res_trap),
   .fatal     (fatal)
);

// File: tb/cfi_landing_checker_test.sv
module cfi_landing_checker_test;

   localparam logic [31:0] BASE  = 32'h0040_0000;
   localparam int unsigned BYTES = 512;
   localparam int unsigned HWN   = BYTES / 2;
   localparam int unsigned HW_W  = $clog2(HWN);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clear = 1'b0, seal = 1'b0;
   logic            rec_valid = 1'b0, rec_len4 = 1'b0, rec_term = 1'b0, rec_host = 1'b0;
   logic [HW_W-1:0] rec_hw = '0;
   logic            chk_valid = 1'b0;
   logic [63:0]     chk_target = '0;
   logic            busy, res_valid, res_pass, res_trap, fatal;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   logic [HWN-1:0] ref_map;
   bit ref_fatal;

   always #2 clk = ~clk;

   cfi_landing_checker #(.CODE_BASE(BASE), .CODE_BYTES(BYTES)) uut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .seal(seal),
      .rec_valid(rec_valid), .rec_hw(rec_hw), .rec_len4(rec_len4),
      .rec_term(rec_term), .rec_host(rec_host),
      .chk_valid(chk_valid), .chk_target(chk_target),
      .busy(busy), .res_valid(res_valid), .res_pass(res_pass),
      .res_trap(res_trap), .fatal(fatal));

   function automatic bit ref_ok(input logic [63:0] t);
      logic [31:0] lo, rel;
      lo  = t[31:0];
      rel = lo - BASE;
      if (lo < BASE) return 1'b0;
      if (rel >= 32'(BYTES)) return 1'b0;
      if (rel[0]) return 1'b0;
      return ref_map[rel[HW_W:1]];
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic do_clear();
      @(negedge clk); clear = 1'b1;
      @(negedge clk); clear = 1'b0;
      ref_map = '0; ref_map[0] = 1'b1; ref_fatal = 1'b0;
   endtask

   task automatic do_seal();
      @(negedge clk); seal = 1'b1;
      @(negedge clk); seal = 1'b0;
   endtask

   task automatic do_rec(input int hw, input bit l4, input bit term, input bit host, input bit model);
      int succ;
      @(negedge clk);
      rec_valid = 1'b1; rec_hw = HW_W'(hw); rec_len4 = l4; rec_term = term; rec_host = host;
      @(negedge clk);
      rec_valid = 1'b0; rec_term = 1'b0; rec_host = 1'b0;
      if (model) begin
         succ = hw + (l4 ? 2 : 1);
         if ((term || host) && succ < HWN) ref_map[succ] = 1'b1;
         if (host) ref_map[hw] = 1'b1;
      end
   endtask

   // Drive one check; result sampled at the next falling edge (one register)
   task automatic do_check(input logic [63:0] t, input string req);
      bit e;
      e = ref_ok(t);
      if (!e) ref_fatal = 1'b1;
      @(negedge clk); chk_valid = 1'b1; chk_target = t;
      @(negedge clk); chk_valid = 1'b0;
      check(req, {4'b0, res_valid, res_pass, res_trap, fatal}, {4'b0, 1'b1, e, !e, ref_fatal});
   endtask

   function automatic logic [63:0] at_hw(input int hw, input bit rnd_hi);
      logic [31:0] hi;
      hi = rnd_hi ? $urandom : 32'h0;
      return {hi, BASE + 32'(2 * hw)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      ref_map = '0; ref_map[0] = 1'b1; ref_fatal = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state of outputs
      check("R6 reset outputs", {3'b0, busy, res_valid, res_pass, res_trap, fatal}, 8'h0);
      // R1 after reset only offset 0
      do_check(at_hw(0, 0), "R1 base after reset");
      do_check(at_hw(1, 0), "R1 base+2 after reset");

      // R7 busy and refusal during build
      do_clear();
      check("R7 busy after clear", {7'b0, busy}, 8'h1);
      check("R8 fatal cleared", {7'b0, fatal}, 8'h0);
      @(negedge clk); chk_valid = 1'b1; chk_target = at_hw(0, 0);
      @(negedge clk); chk_valid = 1'b0;
      check("R7 no result while busy", {7'b0, res_valid}, 8'h0);
      // R2 terminators of both lengths, non-terminator adds nothing
      do_rec(0, 1'b1, 1'b0, 1'b0, 1'b1);
      do_rec(2, 1'b0, 1'b1, 1'b0, 1'b1);
      do_rec(3, 1'b1, 1'b1, 1'b0, 1'b1);
      // R3 host call at 10, 4 bytes
      do_rec(10, 1'b1, 1'b0, 1'b1, 1'b1);
      // R9 terminator in last halfword must not wrap
      do_rec(HWN - 1, 1'b0, 1'b1, 1'b0, 1'b1);
      do_seal();
      check("R7 idle after seal", {7'b0, busy}, 8'h0);
      do_check(at_hw(2, 0), "R2 after non-terminator");
      do_check(at_hw(3, 0), "R2 after 2-byte terminator");
      do_check(at_hw(5, 0), "R2 after 4-byte terminator");
      do_check(at_hw(10, 0), "R3 host own offset");
      do_check(at_hw(12, 0), "R3 host successor");
      do_check(at_hw(0, 0), "R9 offset 0 still start");
      do_check(at_hw(HWN - 1, 0), "R9 last halfword");
      do_check({32'h0, BASE - 32'd2}, "R5 below base");
      do_check({32'h0, BASE + 32'(BYTES)}, "R5 past end");
      do_check(at_hw(3, 0) + 64'd1, "R5 odd offset");
      do_check({32'hDEAD_BEEF, BASE + 32'd6}, "R4 upper bits ignored");
      do_check({32'hFFFF_FFFF, 32'h0}, "R5 zero page");
      // R8 fatal stays after passing check
      do_check(at_hw(0, 0), "R8 fatal sticky");
      // R7 records outside build ignored
      do_rec(20, 1'b0, 1'b1, 1'b1, 1'b0);
      do_check(at_hw(20, 0), "R7 record ignored own");
      do_check(at_hw(21, 0), "R7 record ignored succ");
      // R1 clear empties set
      do_clear(); do_seal();
      do_check(at_hw(0, 0), "R1 base after clear");
      do_check(at_hw(5, 0), "R1 old start cleared");

      // Random builds and checks
      for (int round = 0; round < 20; round++) begin
         int off;
         do_clear();
         off = 0;
         while (off < HWN) begin
            bit l4, tm, hs;
            l4 = ($urandom % 2) == 1;
            tm = ($urandom % 4) == 0;
            hs = ($urandom % 9) == 0;
            do_rec(off, l4, tm, hs, 1'b1);
            off += l4 ? 2 : 1;
         end
         do_seal();
         for (int k = 0; k < 40; k++) begin
            int sel;
            logic [63:0] t;
            sel = $urandom % 8;
            if (sel < 5)       t = at_hw($urandom % HWN, 1'b1);
            else if (sel == 5) t = at_hw($urandom % HWN, 1'b0) + 64'd1;
            else if (sel == 6) t = {32'($urandom), BASE - 32'($urandom % 4096) - 32'd1};
            else               t = {32'($urandom), BASE + 32'(BYTES) + 32'($urandom % 4096)};
            do_check(t, "R2 R3 R4 R5 random");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule